// File: doc/BRIEF.md
# Fixed-Point Execution Unit with Status and Sticky Flags

This block is a 32-bit integer execution stage. On each cycle where `op_valid` is high it takes two operands, an operation code and a shift amount. It registers a result together with a set of condition flags. Arithmetic, compare and bitwise operations update an arithmetic flag group: zero, negative, overflow and carry. Shift operations update a separate shifter flag group: zero, overflow and sign. The floating-point invalid position in the flag word is always 0, because this unit performs no floating-point work.

The flag word holds the outcome of the most recent operation for each group. A second, sticky word collects overflow events from both groups. Once a sticky bit is set it stays set until `sticky_clr` is pulsed. When `sat_en` is high, signed overflow on add or subtract clamps the result to the largest or smallest representable value. When `sat_en` is low, the result wraps around.

All outputs are registered and appear one clock after the operation is accepted.

Top module: `fx_exec_unit`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, CMP=2, AND=3, OR=4, XOR=5, SHL=6 (logical left) and SHR=7 (logical right). ADD writes a+b and SUB writes a-b to `result` modulo 2^32, one clock after the operation is accepted.
- R2: ALU flags sit in `status` bit 0 (zero), bit 1 (negative, result bit 31) and bit 3 (carry). For SUB and CMP, carry is the carry out of a + ~b + 1, so it is 1 when no borrow occurs. For example, -1 + 1 gives zero=1, carry=1, negative=0 and overflow=0.
- R3: `status` bit 2 (ALU overflow) is set on ADD when both operands have the same sign and the sum's sign differs. It is set on SUB or CMP when the operands' signs differ and the difference's sign differs from a.
- R4: When `sat_en` is 1 and an ADD or SUB overflows, `result` is 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative. Overflow stays flagged, and the zero and negative flags follow the clamped value. When `sat_en` is 0, the wrapped value is written.
- R5: CMP updates the ALU flags exactly as SUB would, and leaves `result` unchanged.
- R6: AND, OR and XOR write the bitwise result, set zero and negative from it, and clear overflow and carry.
- R7: SHL and SHR shift a by `shamt` (0 to 63), filling with zeros. Any amount of 32 or more yields 0.
- R8: Shifter flags sit in `status` bit 5 (zero of the result), bit 6 (overflow) and bit 7 (sign, equal to bit 31 of operand a). Overflow is 1 only on SHL when a nonzero bit leaves past bit 31. For example, SHL of 0x7FFFFFFF by 3 gives 0xFFFFFFF8 with zero=0, overflow=1 and sign=0.
- R9: ALU operations leave bits 7:5 unchanged, and shift operations leave bits 3:0 unchanged. Bit 4 (floating-point invalid) is always 0.
- R10: `sticky` bit 0 latches ALU overflow and bit 1 latches shifter overflow. A synchronous `sticky_clr` zeroes both bits, but an overflow accepted in the same cycle still sets its bit.
- R11: After reset, `result`, `status` and `sticky` are 0. In a cycle with `op_valid` low, `result` and `status` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code |
| a | input | 32 | First operand, also the shifted operand |
| b | input | 32 | Second operand |
| shamt | input | 6 | Shift amount |
| sat_en | input | 1 | Saturate on ALU overflow |
| sticky_clr | input | 1 | Clear the sticky word |
| result | output | 32 | Registered result |
| status | output | 8 | Per-operation flag word |
| sticky | output | 2 | Accumulated overflow bits |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Sign-boundary overflow.** A design that detected overflow from the carry instead of from the signs would flag -1 + 1 and miss 0x7FFFFFFF + 1.
- **Borrow-style carry on subtract.** An inverted carry on SUB would show up at once in 5 - 7 and 3 - 3.
- **Saturation direction.** A clamp that chose its limit from the wrapped result, rather than from a, would return the wrong bound for 0x80000000 - 1.
- **Shift corners.** Shift amounts of 32 or more, and the sign flag taken from the operand rather than from the result, catch a truncated shifter.
- **Independent flag groups.** A design that cleared the other group would fail the group-independence checks.
- **Sticky priority.** A design that let a clear override a same-cycle overflow would lose that event.

// File: rtl/fx_exec_pkg.sv
// Package: shared operation codes and flag-word bit positions for the
// fixed-point execution unit. Assumes a 3-bit operation field.
package fx_exec_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_SHL = 3'd6,
        OP_SHR = 3'd7
    } fx_op_e;

    localparam int unsigned ST_Z    = 0;
    localparam int unsigned ST_N    = 1;
    localparam int unsigned ST_V    = 2;
    localparam int unsigned ST_C    = 3;
    localparam int unsigned ST_FI   = 4;
    localparam int unsigned ST_SZ   = 5;
    localparam int unsigned ST_SV   = 6;
    localparam int unsigned ST_SS   = 7;
    localparam int unsigned ST_BITS = 8;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic carry;
    } alu_flags_t;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic sign;
    } shf_flags_t;

endpackage

// File: rtl/fx_alu_core.sv
// Module: combinational add/subtract/logic datapath with flag generation
// and optional signed saturation. Assumes two's-complement operands.
// CMP is computed as SUB; the caller decides whether to write the result.
module fx_alu_core
    import fx_exec_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  fx_op_e             op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               sat_en,
    output logic [WIDTH-1:0]   y,
    output alu_flags_t         flags
);
    localparam logic [WIDTH-1:0] SAT_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SAT_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    logic              is_sub;
    logic [WIDTH-1:0]  b_eff;
    logic [WIDTH:0]    sum_w;
    logic [WIDTH-1:0]  sum;
    logic              arith_ovf;

    // Shared adder: subtraction is a + ~b + 1.
    always_comb begin
        is_sub    = (op == OP_SUB) || (op == OP_CMP);
        b_eff     = is_sub ? ~b : b;
        sum_w     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
        sum       = sum_w[WIDTH-1:0];
        arith_ovf = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end

    // Result select, saturation and flag derivation.
    always_comb begin
        flags.carry = 1'b0;
        flags.ovf   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                flags.carry = sum_w[WIDTH];
                flags.ovf   = arith_ovf;
                if (arith_ovf && sat_en && (op != OP_CMP)) begin
                    y = a[WIDTH-1] ? SAT_MIN : SAT_MAX;
                end else begin
                    y = sum;
                end
            end
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
        flags.zero = (y == '0);
        flags.neg  = y[WIDTH-1];
    end

endmodule

// File: rtl/fx_shift_core.sv
// Module: combinational logical shifter with zero, overflow and sign flags.
// Assumes a shift amount wide enough to express values of WIDTH and above;
// such amounts produce zero.
module fx_shift_core
    import fx_exec_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SHW   = $clog2(WIDTH) + 1
) (
    input  logic               left,
    input  logic [WIDTH-1:0]   a,
    input  logic [SHW-1:0]     amt,
    output logic [WIDTH-1:0]   y,
    output shf_flags_t         flags
);
    logic [2*WIDTH-1:0] wide;
    logic               big;

    // Double-width left shift exposes the bits pushed out of the word.
    always_comb begin
        wide = {{WIDTH{1'b0}}, a} << amt;
        big  = (amt >= SHW'(WIDTH));
    end

    // Result and flags for both directions.
    always_comb begin
        if (left) begin
            y         = big ? '0 : wide[WIDTH-1:0];
            flags.ovf = big ? (a != '0) : (wide[2*WIDTH-1:WIDTH] != '0);
        end else begin
            y         = big ? '0 : (a >> amt);
            flags.ovf = 1'b0;
        end
        flags.zero = (y == '0);
        flags.sign = a[WIDTH-1];
    end

endmodule

// File: rtl/fx_status_regs.sv
// Module: result, per-operation flag word and sticky overflow registers.
// Assumes a synchronous active-low reset. Each accepted operation
// rewrites only its own flag group; the sticky word ORs in new overflow
// after any clear in the same cycle.
module fx_status_regs
    import fx_exec_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               write_res,
    input  logic               is_shift,
    input  logic [WIDTH-1:0]   next_res,
    input  alu_flags_t         alu_f,
    input  shf_flags_t         shf_f,
    input  logic               clr,
    output logic [WIDTH-1:0]   result,
    output logic [ST_BITS-1:0] status,
    output logic [1:0]         sticky
);
    // Result register: loads on accepted non-compare operations.
    always_ff @(posedge clk) begin
        if (!rst_n)                   result <= '0;
        else if (valid && write_res)  result <= next_res;
    end

    // Flag word: the group of the accepted operation is rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (valid) begin
            if (is_shift) begin
                status[ST_SZ] <= shf_f.zero;
                status[ST_SV] <= shf_f.ovf;
                status[ST_SS] <= shf_f.sign;
            end else begin
                status[ST_Z] <= alu_f.zero;
                status[ST_N] <= alu_f.neg;
                status[ST_V] <= alu_f.ovf;
                status[ST_C] <= alu_f.carry;
            end
            status[ST_FI] <= 1'b0;
        end
    end

    // Sticky word: clear first, then accumulate this cycle's overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky[0] <= (sticky[0] && !clr) || (valid && !is_shift && alu_f.ovf);
            sticky[1] <= (sticky[1] && !clr) || (valid &&  is_shift && shf_f.ovf);
        end
    end

endmodule

// File: rtl/fx_exec_unit.sv
// Module: top of the fixed-point execution unit. Decodes the operation,
// routes operands to the ALU and shifter cores and registers the outcome.
// Assumes op, a, b, shamt and sat_en are valid whenever op_valid is high.
module fx_exec_unit
    import fx_exec_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SHW   = $clog2(WIDTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [SHW-1:0]     shamt,
    input  logic               sat_en,
    input  logic               sticky_clr,
    output logic [WIDTH-1:0]   result,
    output logic [ST_BITS-1:0] status,
    output logic [1:0]         sticky
);
    fx_op_e            op_e;
    logic              is_shift;
    logic              write_res;
    logic [WIDTH-1:0]  alu_y;
    logic [WIDTH-1:0]  shf_y;
    alu_flags_t        alu_f;
    shf_flags_t        shf_f;

    // Operation decode.
    always_comb begin
        op_e      = fx_op_e'(op);
        is_shift  = (op_e == OP_SHL) || (op_e == OP_SHR);
        write_res = (op_e != OP_CMP);
    end

    fx_alu_core #(.WIDTH(WIDTH)) u_alu (
        .op     (op_e),
        .a      (a),
        .b      (b),
        .sat_en (sat_en),
        .y      (alu_y),
        .flags  (alu_f)
    );

    fx_shift_core #(.WIDTH(WIDTH), .SHW(SHW)) u_shf (
        .left   (op_e == OP_SHL),
        .a      (a),
        .amt    (shamt),
        .y      (shf_y),
        .flags  (shf_f)
    );

    fx_status_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (op_valid),
        .write_res (write_res),
        .is_shift  (is_shift),
        .next_res  (is_shift ? shf_y : alu_y),
        .alu_f     (alu_f),
        .shf_f     (shf_f),
        .clr       (sticky_clr),
        .result    (result),
        .status    (status),
        .sticky    (sticky)
    );

endmodule

// File: rtl/fx_exec_unit_checker.sv
// Checker: temporal properties of the execution unit's ports, bound to
// every instance of the top module.
module fx_exec_unit_checker #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SHW   = $clog2(WIDTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op,
    input logic             sat_en,
    input logic             sticky_clr,
    input logic [WIDTH-1:0] result,
    input logic [7:0]       status,
    input logic [1:0]       sticky
);
    localparam logic [WIDTH-1:0] SAT_MAX = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SAT_MIN = {1'b1, {(WIDTH-1){1'b0}}};

    // R3 / R4: a saturated overflowing add leaves a clamped value.
    assert_sat_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && sat_en && (op == 3'd0 || op == 3'd1))
        |=> (!status[2] || result == SAT_MAX || result == SAT_MIN));

    // R5: compare never changes the result.
    assert_cmp_keeps_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 3'd2) |=> $stable(result));

    // R6: logic operations clear overflow and carry.
    assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == 3'd3 || op == 3'd4 || op == 3'd5))
        |=> (!status[2] && !status[3]));

    // R2: the ALU zero flag matches the written result.
    assert_zero_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op <= 3'd5) && op != 3'd2) |=> (status[0] == (result == '0)));

    // R9: shift operations leave the ALU group alone.
    assert_shift_keeps_alu_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op >= 3'd6) |=> $stable(status[3:0]));

    // R10: a sticky bit only falls when a clear was requested.
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky[0] && !sticky_clr) |=> sticky[0]);

    // R10: a newly raised ALU overflow is mirrored in the sticky word.
    assert_sticky_catch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> sticky[0]);

    // R11: without an accepted operation, result and flags hold.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(status)));

endmodule

bind fx_exec_unit fx_exec_unit_checker #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op         (op),
    .sat_en     (sat_en),
    .sticky_clr (sticky_clr),
    .result     (result),
    .status     (status),
    .sticky     (sticky)
);

// File: tb/fx_exec_unit_test.sv
// Directed bench for the fixed-point execution unit.
module fx_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [5:0]  shamt = '0;
    logic        sat_en = 1'b0;
    logic        sticky_clr = 1'b0;
    logic [31:0] result;
    logic [7:0]  status;
    logic [1:0]  sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fx_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .a(a), .b(b),
        .shamt(shamt), .sat_en(sat_en), .sticky_clr(sticky_clr),
        .result(result), .status(status), .sticky(sticky)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Issue one operation at a falling edge; outputs are valid at the next one.
    task automatic run_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                          input logic [5:0] s, input logic sat, input logic clr);
        @(negedge clk);
        op = o; a = x; b = y; shamt = s; sat_en = sat; sticky_clr = clr; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; sticky_clr = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 reset result", result, 32'h0);
        check("R11 reset status", {24'h0, status}, 32'h0);
        check("R11 reset sticky", {30'h0, sticky}, 32'h0);
    endtask

    task automatic t_add_basic;
        run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 6'd0, 1'b0, 1'b0);
        check("R1 add -1+1", result, 32'h0);
        check("R2 flags -1+1", {28'h0, status[3:0]}, 32'h9);
        check("R2 sticky after -1+1", {30'h0, sticky}, 32'h0);
    endtask

    task automatic t_add_overflow;
        run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 6'd0, 1'b0, 1'b0);
        check("R3 wrap result", result, 32'h8000_0000);
        check("R3 wrap flags", {28'h0, status[3:0]}, 32'h6);
        check("R10 sticky alu set", {30'h0, sticky}, 32'h1);
        run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 6'd0, 1'b1, 1'b0);
        check("R4 sat add result", result, 32'h7FFF_FFFF);
        check("R4 sat add flags", {28'h0, status[3:0]}, 32'h4);
    endtask

    task automatic t_sub;
        run_op(3'd1, 32'h5, 32'h7, 6'd0, 1'b0, 1'b0);
        check("R1 sub 5-7", result, 32'hFFFF_FFFE);
        check("R2 sub borrow flags", {28'h0, status[3:0]}, 32'h2);
        run_op(3'd1, 32'h8000_0000, 32'h1, 6'd0, 1'b1, 1'b0);
        check("R4 sat sub result", result, 32'h8000_0000);
        check("R4 sat sub flags", {28'h0, status[3:0]}, 32'hE);
    endtask

    task automatic t_compare;
        run_op(3'd1, 32'h10, 32'h3, 6'd0, 1'b0, 1'b0);
        check("R1 sub 16-3", result, 32'hD);
        run_op(3'd2, 32'h3, 32'h3, 6'd0, 1'b0, 1'b0);
        check("R5 cmp keeps result", result, 32'hD);
        check("R5 cmp flags equal", {28'h0, status[3:0]}, 32'h9);
        run_op(3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 6'd0, 1'b1, 1'b0);
        check("R5 cmp overflow result kept", result, 32'hD);
        check("R5 cmp overflow flags", {28'h0, status[3:0]}, 32'h6);
    endtask

    task automatic t_logic;
        run_op(3'd3, 32'h0000_F0F0, 32'h0000_FF00, 6'd0, 1'b0, 1'b0);
        check("R6 and result", result, 32'h0000_F000);
        check("R6 and flags", {28'h0, status[3:0]}, 32'h0);
        run_op(3'd4, 32'h8000_0000, 32'h1, 6'd0, 1'b0, 1'b0);
        check("R6 or result", result, 32'h8000_0001);
        check("R6 or flags", {28'h0, status[3:0]}, 32'h2);
        run_op(3'd5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 6'd0, 1'b0, 1'b0);
        check("R6 xor result", result, 32'h0);
        check("R6 xor flags", {28'h0, status[3:0]}, 32'h1);
    endtask

    task automatic t_shift;
        run_op(3'd6, 32'h7FFF_FFFF, 32'h0, 6'd3, 1'b0, 1'b0);
        check("R7 shl result", result, 32'hFFFF_FFF8);
        check("R8 shl flags", {29'h0, status[7:5]}, 32'h2);
        check("R9 alu group kept", {28'h0, status[3:0]}, 32'h1);
        check("R10 sticky shf set", {30'h0, sticky[1]}, 32'h1);
        run_op(3'd7, 32'h8000_0000, 32'h0, 6'd31, 1'b0, 1'b0);
        check("R7 shr result", result, 32'h1);
        check("R8 shr flags", {29'h0, status[7:5]}, 32'h4);
        run_op(3'd6, 32'h5, 32'h0, 6'd40, 1'b0, 1'b0);
        check("R7 shl big amount", result, 32'h0);
        check("R8 shl big flags", {29'h0, status[7:5]}, 32'h3);
        run_op(3'd7, 32'hFFFF_FFFF, 32'h0, 6'd32, 1'b0, 1'b0);
        check("R7 shr by 32", result, 32'h0);
        check("R8 shr by 32 flags", {29'h0, status[7:5]}, 32'h5);
        run_op(3'd0, 32'h2, 32'h3, 6'd0, 1'b0, 1'b0);
        check("R9 shf group kept", {29'h0, status[7:5]}, 32'h5);
        check("R9 invalid bit zero", {31'h0, status[4]}, 32'h0);
    endtask

    task automatic t_sticky;
        @(negedge clk);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        check("R10 sticky cleared", {30'h0, sticky}, 32'h0);
        check("R10 clear leaves result", result, 32'h5);
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 6'd0, 1'b0, 1'b1);
        check("R10 set wins over clear", {30'h0, sticky}, 32'h1);
        run_op(3'd3, 32'h1, 32'h1, 6'd0, 1'b0, 1'b0);
        check("R10 sticky holds", {30'h0, sticky}, 32'h1);
    endtask

    task automatic t_idle;
        logic [31:0] r0;
        logic [7:0]  s0;
        r0 = result; s0 = status;
        @(negedge clk);
        op = 3'd0; a = 32'h1234; b = 32'h1; sat_en = 1'b0;
        @(negedge clk);
        check("R11 idle result", result, r0);
        check("R11 idle status", {24'h0, status}, {24'h0, s0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_add_basic;
        t_add_overflow;
        t_sub;
        t_compare;
        t_logic;
        t_shift;
        t_sticky;
        t_idle;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule